// File: doc/BRIEF.md
# Power Domain Mode Resolver

This block decides the power mode of a single power domain in a system with two CPU subsystems. Each CPU subsystem reports whether it is running, sleeping (CPU clock halted, its peripherals clocked according to their own low-power enables) or stopped (CPU and peripheral clocks halted). The domain stays clocked while any CPU that uses it is active. Here "uses it" means its own CPU, or the other CPU when that CPU owns a peripheral in this domain.

When every CPU that uses the domain has stopped, the domain may drop to a lower-power mode. The choice between those modes is made by a vector of deep-sleep select bits, one for each requester. A single request for stop overrides any number of requests for standby. In stop the bus-matrix clock is gated but power is kept. Standby is entered only when all requesters agree to it, and it powers the domain down. The resolved mode is registered on the domain clock. The bus-matrix clock enable and the power-down request follow from that registered mode. A one-cycle restore pulse marks every exit from standby.

Top module: `pdm_resolver`

## Requirements
- R1: While and after reset the mode is run (2'b00), `bus_clk_en` is 1, `pwr_down_req` is 0 and `pwr_restore` is 0.
- R2: When the own CPU state is run (2'b00) or sleep (2'b01), the mode one clock later is run with `bus_clk_en` at 1.
- R3: When `peer_owns` is 1 and the peer CPU state is run or sleep, the mode one clock later is run, even if the own CPU is stopped (2'b10).
- R4: When the own CPU is stopped, the peer either owns nothing or is also stopped, and at least one `dsel` bit is 0 (stop), the mode one clock later is stop (2'b01), with `bus_clk_en` 0 and `pwr_down_req` 0.
- R5: Under the same CPU conditions with every `dsel` bit at 1 (standby), the mode one clock later is standby (2'b10), with `bus_clk_en` 0 and `pwr_down_req` 1.
- R6: The CPU state code 2'b11 counts as run, both for the own CPU and for an owning peer.
- R7: From stop or standby, the return of a relevant CPU to run or sleep brings the mode back to run on the next clock.
- R8: `pwr_restore` is 1 for exactly the one cycle in which the mode first differs from standby after having been standby. This covers exits to run and exits to stop.
- R9: A single `dsel` bit at 0 gives stop, whatever its position and however many other bits are 1.
- R10: While `peer_owns` is 0, the peer CPU state has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_state | input | 2 | Own CPU state: 00 run, 01 sleep, 10 stop, 11 treated as run |
| peer_state | input | 2 | Peer CPU state, same encoding |
| peer_owns | input | 1 | Peer CPU has at least one peripheral allocated in this domain |
| dsel | input | NUM_REQ | Deep-sleep select per requester: 0 stop, 1 standby |
| mode_o | output | 2 | Registered domain mode: 00 run, 01 stop, 10 standby |
| bus_clk_en | output | 1 | Bus-matrix clock enable |
| pwr_down_req | output | 1 | Request to power the domain down |
| pwr_restore | output | 1 | One-cycle pulse on leaving standby |

## Verification
The bench builds the block with NUM_REQ set to 3 rather than the default 2. This makes it possible to put a lone stop request in the first, middle and last positions of the select vector while the other bits ask for standby, which exercises the stop-wins rule. With three bits, the all-standby case also needs every bit of a wider reduction to agree. The stimulus walks the mode through exits from standby into both run and stop, so the restore pulse is seen on each kind of exit.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
   typedef enum logic [1:0] {
      DM_RUN     = 2'b00,
      DM_STOP    = 2'b01,
      DM_STANDBY = 2'b10
   } dom_mode_e;

   localparam int unsigned CS_W = 2;
   localparam logic [CS_W-1:0] CS_STOP = 2'b10;
endpackage

// File: rtl/pdm_cpu_decode.sv
module pdm_cpu_decode
   import pdm_pkg::*;
(
   input  logic [CS_W-1:0] state_i,
   output logic            active_o
);
   // Only the explicit stop code halts the CPU; run, sleep and the
   // unused code all keep the domain clocked.
   always_comb begin
      active_o = (state_i != CS_STOP);
   end
endmodule

// File: rtl/pdm_sel_reduce.sv
module pdm_sel_reduce #(
   parameter int unsigned NUM_REQ = 2
) (
   input  logic [NUM_REQ-1:0] sel_i,
   output logic               any_stop_o
);
   generate
      if (NUM_REQ < 1) begin : g_bad
         $error("pdm_sel_reduce: NUM_REQ must be at least 1");
      end else if (NUM_REQ == 1) begin : g_single
         assign any_stop_o = ~sel_i[0];
      end else begin : g_multi
         logic [NUM_REQ-1:0] stop_vec;
         for (genvar i = 0; i < NUM_REQ; i++) begin : g_bit
            assign stop_vec[i] = ~sel_i[i];
         end
         assign any_stop_o = |stop_vec;
      end
   endgenerate
endmodule

// File: rtl/pdm_mode_reg.sv
module pdm_mode_reg
   import pdm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  dom_mode_e next_i,
   output dom_mode_e mode_o,
   output logic      restore_o
);
   dom_mode_e mode_q;
   logic      restore_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= DM_RUN;
         restore_q <= 1'b0;
      end else begin
         mode_q    <= next_i;
         restore_q <= (mode_q == DM_STANDBY) && (next_i != DM_STANDBY);
      end
   end

   assign mode_o    = mode_q;
   assign restore_o = restore_q;
endmodule

// File: rtl/pdm_resolver.sv
module pdm_resolver
   import pdm_pkg::*;
#(
   parameter int unsigned NUM_REQ = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         own_state,
   input  logic [1:0]         peer_state,
   input  logic               peer_owns,
   input  logic [NUM_REQ-1:0] dsel,
   output logic [1:0]         mode_o,
   output logic               bus_clk_en,
   output logic               pwr_down_req,
   output logic               pwr_restore
);
   logic      own_act;
   logic      peer_act;
   logic      hold_run;
   logic      any_stop;
   dom_mode_e next_mode;
   dom_mode_e cur_mode;

   pdm_cpu_decode own_dec_i  (.state_i(own_state),  .active_o(own_act));
   pdm_cpu_decode peer_dec_i (.state_i(peer_state), .active_o(peer_act));

   pdm_sel_reduce #(.NUM_REQ(NUM_REQ)) sel_i (
      .sel_i      (dsel),
      .any_stop_o (any_stop)
   );

   always_comb begin
      hold_run = own_act | (peer_owns & peer_act);
      if (hold_run)      next_mode = DM_RUN;
      else if (any_stop) next_mode = DM_STOP;
      else               next_mode = DM_STANDBY;
   end

   pdm_mode_reg mode_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .next_i    (next_mode),
      .mode_o    (cur_mode),
      .restore_o (pwr_restore)
   );

   assign mode_o       = cur_mode;
   assign bus_clk_en   = (cur_mode == DM_RUN);
   assign pwr_down_req = (cur_mode == DM_STANDBY);
endmodule

// File: rtl/pdm_resolver_chk.sv
module pdm_resolver_chk #(
   parameter int unsigned NUM_REQ = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         own_state,
   input logic [1:0]         peer_state,
   input logic               peer_owns,
   input logic [NUM_REQ-1:0] dsel,
   input logic [1:0]         mode_o,
   input logic               bus_clk_en,
   input logic               pwr_down_req,
   input logic               pwr_restore
);
   logic may_leave;
   assign may_leave = (own_state == 2'b10) && (!peer_owns || peer_state == 2'b10);

   AST_OWN_ACTIVE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (own_state != 2'b10) |=> (mode_o == 2'b00 && bus_clk_en)); // R2
   AST_PEER_ACTIVE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (peer_owns && peer_state != 2'b10) |=> (mode_o == 2'b00)); // R3
   AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (may_leave && !(&dsel)) |=> (mode_o == 2'b01 && !bus_clk_en && !pwr_down_req)); // R4
   AST_STANDBY_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (may_leave && (&dsel)) |=> (mode_o == 2'b10 && pwr_down_req)); // R5
   AST_NO_CLK_IN_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down_req |-> !bus_clk_en); // R5
   AST_RESTORE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_restore |-> ($past(mode_o) == 2'b10 && mode_o != 2'b10)); // R8
   AST_RESTORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_restore |=> !pwr_restore); // R8
endmodule

bind pdm_resolver pdm_resolver_chk #(.NUM_REQ(NUM_REQ)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .own_state    (own_state),
   .peer_state   (peer_state),
   .peer_owns    (peer_owns),
   .dsel         (dsel),
   .mode_o       (mode_o),
   .bus_clk_en   (bus_clk_en),
   .pwr_down_req (pwr_down_req),
   .pwr_restore  (pwr_restore)
);

// File: tb/pdm_resolver_tb_top.sv
`timescale 1ns/1ps
module pdm_resolver_tb_top;
   localparam int unsigned NREQ = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      own_state = 2'b00;
   logic [1:0]      peer_state = 2'b00;
   logic            peer_owns = 1'b0;
   logic [NREQ-1:0] dsel = '1;
   logic [1:0]      mode_o;
   logic            bus_clk_en;
   logic            pwr_down_req;
   logic            pwr_restore;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // expected item: {mode[1:0], clk_en, pd, restore}
   logic [4:0] exp_q[$];
   string      tag_q[$];
   logic [1:0] prev_mode = 2'b00;

   always #2.5 clk = ~clk;

   pdm_resolver #(.NUM_REQ(NREQ)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .own_state    (own_state),
      .peer_state   (peer_state),
      .peer_owns    (peer_owns),
      .dsel         (dsel),
      .mode_o       (mode_o),
      .bus_clk_en   (bus_clk_en),
      .pwr_down_req (pwr_down_req),
      .pwr_restore  (pwr_restore)
   );

   function automatic logic [1:0] model_mode(input logic [1:0] o, input logic [1:0] p,
                                             input logic ow, input logic [NREQ-1:0] s);
      logic o_act = (o != 2'b10);
      logic p_act = (p != 2'b10);
      if (o_act || (ow && p_act)) return 2'b00;
      if (s != '1) return 2'b01;
      return 2'b10;
   endfunction

   task automatic compare(input logic [4:0] exp, input string tag);
      logic [4:0] act = {mode_o, bus_clk_en, pwr_down_req, pwr_restore};
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: got mode=%b clk_en=%b pd=%b restore=%b, expected mode=%b clk_en=%b pd=%b restore=%b",
                  tag, act[4:3], act[2], act[1], act[0], exp[4:3], exp[2], exp[1], exp[0]);
      end
   endtask

   task automatic drive(input logic [1:0] o, input logic [1:0] p, input logic ow,
                        input logic [NREQ-1:0] s, input string tag);
      logic [1:0] m;
      logic       rs;
      @(negedge clk);
      own_state  = o;
      peer_state = p;
      peer_owns  = ow;
      dsel       = s;
      m  = model_mode(o, p, ow, s);
      rs = (prev_mode == 2'b10) && (m != 2'b10);
      exp_q.push_back({m, m == 2'b00, m == 2'b10, rs});
      tag_q.push_back(tag);
      prev_mode = m;
   endtask

   // monitor: results appear one edge after the inputs are applied
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
      end
   end

   initial begin
      #(200000 * 5);
      failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      compare(5'b00_1_0_0, "R1 reset state");
      @(negedge clk);
      rst_n = 1'b1;

      drive(2'b00, 2'b10, 1'b0, 3'b111, "R2 own run");
      drive(2'b01, 2'b10, 1'b0, 3'b111, "R2 own sleep");
      drive(2'b10, 2'b00, 1'b0, 3'b111, "R5 R10 standby, non-owning peer running");
      drive(2'b10, 2'b01, 1'b0, 3'b111, "R5 R10 standby held");
      drive(2'b10, 2'b01, 1'b1, 3'b111, "R3 R8 owning peer sleep wakes domain");
      drive(2'b10, 2'b01, 1'b1, 3'b111, "R8 restore lasts one cycle");
      drive(2'b10, 2'b10, 1'b1, 3'b101, "R4 R9 middle stop bit");
      drive(2'b10, 2'b10, 1'b1, 3'b110, "R9 low stop bit");
      drive(2'b10, 2'b10, 1'b1, 3'b111, "R5 all standby");
      drive(2'b10, 2'b10, 1'b1, 3'b011, "R8 R9 standby to stop via high bit");
      drive(2'b11, 2'b10, 1'b1, 3'b000, "R6 R7 own code 11 as run");
      drive(2'b10, 2'b11, 1'b1, 3'b000, "R6 owning peer code 11 as run");
      drive(2'b10, 2'b11, 1'b0, 3'b000, "R10 non-owning peer 11 ignored");
      drive(2'b10, 2'b10, 1'b1, 3'b111, "R5 standby again");
      drive(2'b00, 2'b10, 1'b1, 3'b111, "R7 R8 own run leaves standby");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule